// File: doc/BRIEF.md
# Register-Exchange Survivor Store with Column Gating

This block keeps the survivor paths of a four-state trellis decoder for a rate-1/2 code whose generators are 7 and 5 (octal). Every state owns an L-bit survivor register. On each cycle that carries a fresh set of decisions, every register is rebuilt from the register of the predecessor its decision bit selects, shifted by one place, with the state's own input bit entered at the newest end. The oldest position of the registers therefore holds the decoded bit of the step taken L steps earlier, and no trace-back is needed.

One decoded bit is presented each cycle under a policy picked at run time: follow the best state reported by the metric logic, always read state 0, or take a majority vote over the four oldest bits. The columns are split into fixed-width groups. A group beyond the first is held (its write enable dropped) when the survivors have merged over it and the shift would rewrite the bits it already holds, and it resumes in the first cycle that condition fails.

Top module: `rx_survivor`

## Requirements
- R1: While rst_n is low and until the first valid step after it, out_valid is 0, all survivor bits are 0 (out_bit reads 0 in every mode) and grp_active shows only group 0 active.
- R2: State n is written as the 2-bit number {newest input, previous input}. On a step with in_valid high, the register of state n becomes the register of state {n[0], dec[n]} shifted one place toward the old end, with n[1] entered at bit 0 (newest); bit L-1 is the oldest.
- R3: With mode 2'b00, out_bit is bit L-1 of the register of the state given on best during the latest valid step (state 0 before any).
- R4: With mode 2'b01, out_bit is bit L-1 of the register of state 0.
- R5: With mode[1] high, out_bit is 1 when three or four of the bits at position L-1 are 1, and 0 otherwise, so a two-two tie gives 0.
- R6: out_valid goes high once L valid steps have been taken since reset and stays high until the next reset.
- R7: A cycle with in_valid low changes no survivor bit and no recorded best state.
- R8: Columns are grouped GW at a time, group g covering bits g*GW to g*GW+GW-1. For g of 1 or more, grp_active[g] is 0 exactly when all bits of all four registers in columns g*GW-1 through g*GW+GW-1 are equal; grp_active[0] is always 1.
- R9: An inactive group is not written, and a group is written again in the same cycle its merge condition fails, so the decoded stream is identical to that of an ungated store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decision set is present this cycle |
| dec | input | 4 | One decision bit per state, bit n for state n |
| best | input | 2 | State with the smallest metric after this step |
| mode | input | 2 | Output policy: 00 best, 01 state 0, 1x majority |
| out_valid | output | 1 | out_bit carries a decoded bit |
| out_bit | output | 1 | Decoded bit from the oldest column |
| grp_active | output | L/GW | Write enable of each column group |

## Verification
The assertions assume that in_valid, dec and best are settled before each rising edge and that best names a state; they place no condition on the decision pattern itself. The stimulus drives all inputs on the falling edge, mixes idle cycles into the stream, and alternates all-zero decision runs, which merge the deep columns and drop their enables, with random runs that break the merge, so gating and release are both reached while every policy is in use.

// File: rtl/rx_survivor.sv
module rx_survivor #(
  parameter int L  = 16,
  parameter int GW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        dec,
  input  logic [1:0]        best,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic              out_bit,
  output logic [L/GW-1:0]   grp_active
);
  localparam int NS = 4;
  localparam int NG = L / GW;
  localparam int CW = $clog2(L + 1);

  logic [L-1:0]   sr [NS];
  logic [L-1:0]   nv [NS];
  logic [1:0]     best_q;
  logic [CW-1:0]  cnt;
  logic [NS*L-1:0] sr_flat;
  logic [NS-1:0]  oldest;
  logic [2:0]     ones;

  assign sr_flat = {sr[3], sr[2], sr[1], sr[0]};

  always_comb begin
    for (int n = 0; n < NS; n++) begin
      logic [1:0] p;
      p = {n[0], dec[n]};
      nv[n] = {sr[p][L-2:0], n[1]};
    end
  end

  assign grp_active[0] = 1'b1;
  for (genvar g = 1; g < NG; g++) begin : g_merge
    localparam int LO = g * GW - 1;
    localparam int HI = g * GW + GW - 1;
    logic [NS*(GW+1)-1:0] win;
    assign win = {sr[3][HI:LO], sr[2][HI:LO], sr[1][HI:LO], sr[0][HI:LO]};
    assign grp_active[g] = !((&win) || !(|win));
  end

  for (genvar n = 0; n < NS; n++) begin : g_state
    for (genvar g = 0; g < NG; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (!rst_n)
          sr[n][g*GW +: GW] <= '0;
        else if (in_valid && grp_active[g])
          sr[n][g*GW +: GW] <= nv[n][g*GW +: GW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q <= '0;
      cnt    <= '0;
    end else if (in_valid) begin
      best_q <= best;
      if (cnt != CW'(L)) cnt <= cnt + 1'b1;
    end
  end

  for (genvar n = 0; n < NS; n++) begin : g_old
    assign oldest[n] = sr[n][L-1];
  end
  assign ones = 3'(oldest[0]) + 3'(oldest[1]) + 3'(oldest[2]) + 3'(oldest[3]);

  assign out_valid = (cnt == CW'(L));
  assign out_bit   = mode[1] ? (ones > 3'd2) :
                     mode[0] ? oldest[0] : oldest[best_q];
endmodule

module rx_survivor_chk #(
  parameter int L  = 16,
  parameter int GW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [L/GW-1:0] grp_active,
  input logic [4*L-1:0]  sr_flat
);
  localparam int NG = L / GW;

  p_newbit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!sr_flat[0] && !sr_flat[L] && sr_flat[2*L] && sr_flat[3*L]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sr_flat));

  for (genvar s = 0; s < 4; s++) begin : g_s
    for (genvar g = 1; g < NG; g++) begin : g_g
      p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !grp_active[g]) |=> $stable(sr_flat[s*L + g*GW +: GW]));
    end
  end
endmodule

bind rx_survivor rx_survivor_chk #(.L(L), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .grp_active(grp_active), .sr_flat(sr_flat)
);

// File: tb/tb_rx_survivor.sv
module tb_rx_survivor;
  localparam int L  = 16;
  localparam int GW = 4;
  localparam int NG = L / GW;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [3:0] dec = '0;
  logic [1:0] best = '0, mode = '0;
  logic out_valid, out_bit;
  logic [NG-1:0] grp_active;

  rx_survivor #(.L(L), .GW(GW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, ties = 0, gated = 0;
  bit done = 0;

  logic [L-1:0] m [4];
  logic [1:0] mbest;
  int msteps;
  logic q_v[$], q_b[$];
  logic [NG-1:0] q_g[$];
  logic [1:0] q_m[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_grp();
    logic [NG-1:0] e;
    e[0] = 1'b1;
    for (int g = 1; g < NG; g++) begin
      int c1, c0;
      c1 = 0; c0 = 0;
      for (int s = 0; s < 4; s++)
        for (int b = g*GW-1; b <= g*GW+GW-1; b++)
          if (m[s][b]) c1++; else c0++;
      e[g] = (c1 != 0 && c0 != 0);
    end
    return e;
  endfunction

  task automatic step(logic v, logic [3:0] d, logic [1:0] b, logic [1:0] md);
    logic [L-1:0] nx [4];
    int ones;
    logic eb;
    @(negedge clk);
    in_valid = v; dec = d; best = b; mode = md;
    @(posedge clk);
    if (v) begin
      for (int n = 0; n < 4; n++)
        nx[n] = {m[{n[0], d[n]}][L-2:0], n[1]};
      for (int n = 0; n < 4; n++) m[n] = nx[n];
      mbest = b;
      if (msteps < L) msteps++;
    end
    ones = 0;
    for (int n = 0; n < 4; n++) ones += int'(m[n][L-1]);
    if (md[1]) begin
      eb = (ones > 2);
      if (ones == 2 && msteps == L) ties++;
    end else if (md[0]) eb = m[0][L-1];
    else eb = m[mbest][L-1];
    q_v.push_back(msteps == L);
    q_b.push_back(eb);
    q_g.push_back(exp_grp());
    q_m.push_back(md);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_v.size() > 0) begin
      logic ev, eb;
      logic [NG-1:0] eg;
      logic [1:0] md;
      ev = q_v.pop_front(); eb = q_b.pop_front();
      eg = q_g.pop_front(); md = q_m.pop_front();
      chk("R6 out_valid", out_valid, ev);
      chk("R8 grp_active", grp_active, eg);
      if (eg != '1) gated++;
      if (ev) begin
        if (md[1])      chk("R5/R9 majority", out_bit, eb);
        else if (md[0]) chk("R4/R9 fixed", out_bit, eb);
        else            chk("R3/R9 best", out_bit, eb);
      end
    end
  end

  task automatic run_random(int n, int pv, logic [1:0] md);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pv, 4'($urandom), 2'($urandom), md);
  endtask

  initial begin
    for (int n = 0; n < 4; n++) m[n] = '0;
    mbest = '0; msteps = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 grp in reset", grp_active, NG'(1));
    rst_n = 1;
    @(negedge clk);
    for (int md = 0; md < 4; md++) begin
      mode = 2'(md);
      #1 chk("R1 out_bit after reset", out_bit, 0);
    end
    chk("R1 out_valid after reset", out_valid, 0);
    // R2/R6: exactly L steps with idle gaps (R7)
    for (int i = 0; i < L; i++) begin
      step(1, 4'($urandom), 2'($urandom), 2'b01);
      step(0, 4'($urandom), 2'($urandom), 2'b01);
    end
    // merge runs: all-zero decisions gate deep groups (R8)
    for (int i = 0; i < 3*L; i++) step(1, 4'h0, 2'd0, 2'b01);
    run_random(400, 85, 2'b00);
    for (int i = 0; i < 3*L; i++) step(1, 4'h0, 2'd1, 2'b00);
    run_random(400, 85, 2'b01);
    for (int i = 0; i < 3*L; i++) step(1, 4'hF, 2'd3, 2'b10);
    run_random(600, 85, 2'b10);
    run_random(300, 90, 2'b11);
    for (int i = 0; i < 3*L; i++) step(1, 4'h0, 2'd2, 2'b11);
    for (int k = 0; k < 200; k++) step(1, 4'($urandom), 2'($urandom), 2'($urandom));
    repeat (3) @(posedge clk);
    #3;
    chk("R5 tie cases seen", ties > 0, 1);
    chk("R8 gated cycles seen", gated > 0, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule